// File: doc/BRIEF.md
# Register Scoreboard Hazard Checker

This block schedules instructions for a small register file shared by a few functional units. Each incoming instruction names one destination register, up to two source registers (each with its own enable) and the unit that will run it. The block keeps a hazard-prone tag bit per register and a reservation flag per unit. It holds back an instruction at issue on a write-after-write conflict or a busy unit. It holds back operand reads until every source is valid, which covers read-after-write. It holds back a unit's result write while an older, unread instruction still needs the register's previous value, which covers write-after-read.

Instructions enter on a valid/ready stream. An instruction is taken in a cycle where `iss_valid` and `iss_ready` are both high. `iss_ready` is a combinational function of the current payload (`iss_dst`, `iss_unit`) and the block's state, so the payload must stay stable while `iss_valid` waits for `iss_ready`. Each unit then follows a plain handshake. `rd_go` tells the unit its operands may be read, and the unit answers with `rd_done`. When the unit is ready to write back, it raises `wb_req` and holds it until `wb_grant` arrives. A grant releases the unit and the destination tag.

Top module: `reg_scoreboard`

## Requirements
- R1: While reset is asserted, and after it is released, every `reg_busy` bit and every `unit_busy` bit reads 0 and `rd_go` is all zero.
- R2: `iss_ready` is low whenever `reg_busy[iss_dst]` is 1 (write-after-write), so no second write to a register is issued while one is pending.
- R3: `iss_ready` is low whenever `unit_busy[iss_unit]` is 1. An accepted instruction sets `reg_busy[iss_dst]` and `unit_busy[iss_unit]` from the next cycle on.
- R4: A unit's `rd_go` stays low while any enabled source register had a pending write when the instruction was issued and that write has not yet completed. A source whose enable is 0 never holds `rd_go` low.
- R5: A write-back granted in a cycle makes its register valid in that same cycle. A waiting unit whose last missing source is that register sees `rd_go` high in that cycle. An instruction issued in that cycle does not wait for that register.
- R6: `rd_go` is high only for a unit that is reserved and has not yet read its operands. `rd_done` moves a unit past its read only when its `rd_go` is high; otherwise `rd_done` is ignored.
- R7: `wb_grant` for a unit writing register X is withheld while another unit that has not yet read its operands has an enabled source X that it must read before this write (write-after-read).
- R8: At most one `wb_grant` bit is high per cycle. A grant goes only to a unit that requests it and has already read its operands. Among eligible units the lowest index wins.
- R9: In the cycle after `wb_grant[u]`, `unit_busy[u]` and the tag bit of that unit's destination register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Instruction offered for issue |
| iss_ready | output | 1 | Instruction can be accepted this cycle |
| iss_dst | input | $clog2(NREG) | Destination register |
| iss_src_a | input | $clog2(NREG) | First source register |
| iss_use_a | input | 1 | First source is used |
| iss_src_b | input | $clog2(NREG) | Second source register |
| iss_use_b | input | 1 | Second source is used |
| iss_unit | input | $clog2(NFU) | Functional unit selected |
| rd_go | output | NFU | Per unit: operands are valid and may be read |
| rd_done | input | NFU | Per unit: operands have been read |
| wb_req | input | NFU | Per unit: result ready to write back |
| wb_grant | output | NFU | Per unit: write-back allowed this cycle |
| reg_busy | output | NREG | Per register hazard-prone tag (pending write) |
| unit_busy | output | NFU | Per unit reservation flag |

## Verification
On every cycle, the bound checker enforces the issue blocking on a pending destination or a busy unit. It also checks the tag and reservation set after issue, the single grant to a requesting unit, the release of a unit after its grant, and that `rd_go` appears only for reserved units. The ordering behaviours need whole instruction sequences, so only the bench scenarios show them. These are the read-after-write wait and its same-cycle release on write-back, the write-after-read hold while an older reader is still unread, the lowest-index choice between two eligible writers, and the ignoring of disabled sources and stray `rd_done` pulses.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_EXEC = 2'd2
  } slot_st_e;
endpackage

// File: rtl/sb_regtags.sv
// Per-register hazard-prone tag bits: set by an issued write, cleared by its completion.
module sb_regtags #(
  parameter int NREG = 8,
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [RW-1:0]   set_reg,
  input  logic            clr_en,
  input  logic [RW-1:0]   clr_reg,
  output logic [NREG-1:0] pending
);
  for (genvar r = 0; r < NREG; r++) begin : g_tag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pending[r] <= 1'b0;
      end else if (set_en && set_reg == RW'(r)) begin
        pending[r] <= 1'b1;
      end else if (clr_en && clr_reg == RW'(r)) begin
        pending[r] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sb_unit_slot.sv
// One functional unit's reservation: idle, waiting for operands, executing.
module sb_unit_slot
  import sb_pkg::*;
#(
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [RW-1:0] ld_dst,
  input  logic [RW-1:0] ld_src_a,
  input  logic          ld_use_a,
  input  logic          ld_wait_a,
  input  logic [RW-1:0] ld_src_b,
  input  logic          ld_use_b,
  input  logic          ld_wait_b,
  input  logic          wr_valid,
  input  logic [RW-1:0] wr_reg,
  input  logic          wr_self,
  input  logic          rd_done,
  output logic          busy,
  output logic          waiting,
  output logic          executing,
  output logic [RW-1:0] dst,
  output logic [RW-1:0] src_a,
  output logic          use_a,
  output logic          wait_a,
  output logic [RW-1:0] src_b,
  output logic          use_b,
  output logic          wait_b,
  output logic          rd_go
);
  slot_st_e st;
  logic     hit_a, hit_b, ok_a, ok_b;

  assign busy      = (st != SLOT_IDLE);
  assign waiting   = (st == SLOT_WAIT);
  assign executing = (st == SLOT_EXEC);

  // A completion in this cycle releases a waiting source at once (bypass).
  assign hit_a = wr_valid && (wr_reg == src_a);
  assign hit_b = wr_valid && (wr_reg == src_b);
  assign ok_a  = !use_a || !wait_a || hit_a;
  assign ok_b  = !use_b || !wait_b || hit_b;
  assign rd_go = waiting && ok_a && ok_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SLOT_IDLE;
      dst    <= '0;
      src_a  <= '0;
      src_b  <= '0;
      use_a  <= 1'b0;
      use_b  <= 1'b0;
      wait_a <= 1'b0;
      wait_b <= 1'b0;
    end else begin
      unique case (st)
        SLOT_IDLE: begin
          if (load) begin
            st     <= SLOT_WAIT;
            dst    <= ld_dst;
            src_a  <= ld_src_a;
            src_b  <= ld_src_b;
            use_a  <= ld_use_a;
            use_b  <= ld_use_b;
            wait_a <= ld_use_a && ld_wait_a;
            wait_b <= ld_use_b && ld_wait_b;
          end
        end
        SLOT_WAIT: begin
          if (hit_a) wait_a <= 1'b0;
          if (hit_b) wait_b <= 1'b0;
          if (rd_done && rd_go) begin
            st    <= SLOT_EXEC;
            use_a <= 1'b0;
            use_b <= 1'b0;
          end
        end
        SLOT_EXEC: begin
          if (wr_self) st <= SLOT_IDLE;
        end
        default: st <= SLOT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sb_wb_arb.sv
// Write-back arbiter: blocks write-after-read conflicts, grants the lowest eligible unit.
module sb_wb_arb #(
  parameter int NFU = 4,
  parameter int RW  = 3
) (
  input  logic [NFU-1:0]         executing,
  input  logic [NFU-1:0]         wb_req,
  input  logic [NFU-1:0]         waiting,
  input  logic [NFU-1:0][RW-1:0] dst,
  input  logic [NFU-1:0][RW-1:0] src_a,
  input  logic [NFU-1:0]         use_a,
  input  logic [NFU-1:0]         wait_a,
  input  logic [NFU-1:0][RW-1:0] src_b,
  input  logic [NFU-1:0]         use_b,
  input  logic [NFU-1:0]         wait_b,
  output logic [NFU-1:0]         grant
);
  logic [NFU-1:0] war_hit;
  logic [NFU-1:0] eligible;

  for (genvar f = 0; f < NFU; f++) begin : g_war
    always_comb begin
      war_hit[f] = 1'b0;
      for (int g = 0; g < NFU; g++) begin
        // An unread source not waiting on a write wants the current (old) value.
        if (waiting[g] &&
            ((use_a[g] && !wait_a[g] && src_a[g] == dst[f]) ||
             (use_b[g] && !wait_b[g] && src_b[g] == dst[f]))) begin
          war_hit[f] = 1'b1;
        end
      end
    end
  end

  assign eligible = executing & wb_req & ~war_hit;
  assign grant    = eligible & (~eligible + NFU'(1));
endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard #(
  parameter int NREG = 8,
  parameter int NFU  = 4,
  localparam int RW = $clog2(NREG),
  localparam int UW = $clog2(NFU)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_valid,
  output logic            iss_ready,
  input  logic [RW-1:0]   iss_dst,
  input  logic [RW-1:0]   iss_src_a,
  input  logic            iss_use_a,
  input  logic [RW-1:0]   iss_src_b,
  input  logic            iss_use_b,
  input  logic [UW-1:0]   iss_unit,
  output logic [NFU-1:0]  rd_go,
  input  logic [NFU-1:0]  rd_done,
  input  logic [NFU-1:0]  wb_req,
  output logic [NFU-1:0]  wb_grant,
  output logic [NREG-1:0] reg_busy,
  output logic [NFU-1:0]  unit_busy
);
  logic                   iss_fire;
  logic                   wr_valid;
  logic [RW-1:0]          wr_reg;
  logic                   ld_wait_a, ld_wait_b;
  logic [NFU-1:0]         waiting, executing;
  logic [NFU-1:0][RW-1:0] dst_q, src_a_q, src_b_q;
  logic [NFU-1:0]         use_a_q, use_b_q, wait_a_q, wait_b_q;

  assign iss_ready = !reg_busy[iss_dst] && !unit_busy[iss_unit];
  assign iss_fire  = iss_valid && iss_ready;

  assign wr_valid = |wb_grant;
  always_comb begin
    wr_reg = '0;
    for (int i = 0; i < NFU; i++) begin
      if (wb_grant[i]) wr_reg = dst_q[i];
    end
  end

  // A source completing in the issue cycle is already valid.
  assign ld_wait_a = reg_busy[iss_src_a] && !(wr_valid && wr_reg == iss_src_a);
  assign ld_wait_b = reg_busy[iss_src_b] && !(wr_valid && wr_reg == iss_src_b);

  sb_regtags #(.NREG(NREG)) tags_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (iss_fire),
    .set_reg (iss_dst),
    .clr_en  (wr_valid),
    .clr_reg (wr_reg),
    .pending (reg_busy)
  );

  for (genvar u = 0; u < NFU; u++) begin : g_slot
    sb_unit_slot #(.RW(RW)) slot_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (iss_fire && iss_unit == UW'(u)),
      .ld_dst    (iss_dst),
      .ld_src_a  (iss_src_a),
      .ld_use_a  (iss_use_a),
      .ld_wait_a (ld_wait_a),
      .ld_src_b  (iss_src_b),
      .ld_use_b  (iss_use_b),
      .ld_wait_b (ld_wait_b),
      .wr_valid  (wr_valid),
      .wr_reg    (wr_reg),
      .wr_self   (wb_grant[u]),
      .rd_done   (rd_done[u]),
      .busy      (unit_busy[u]),
      .waiting   (waiting[u]),
      .executing (executing[u]),
      .dst       (dst_q[u]),
      .src_a     (src_a_q[u]),
      .use_a     (use_a_q[u]),
      .wait_a    (wait_a_q[u]),
      .src_b     (src_b_q[u]),
      .use_b     (use_b_q[u]),
      .wait_b    (wait_b_q[u]),
      .rd_go     (rd_go[u])
    );
  end

  sb_wb_arb #(.NFU(NFU), .RW(RW)) arb_i (
    .executing (executing),
    .wb_req    (wb_req),
    .waiting   (waiting),
    .dst       (dst_q),
    .src_a     (src_a_q),
    .use_a     (use_a_q),
    .wait_a    (wait_a_q),
    .src_b     (src_b_q),
    .use_b     (use_b_q),
    .wait_b    (wait_b_q),
    .grant     (wb_grant)
  );
endmodule

// File: rtl/reg_scoreboard_chk.sv
module reg_scoreboard_chk #(
  parameter int NREG = 8,
  parameter int NFU  = 4,
  localparam int RW = $clog2(NREG),
  localparam int UW = $clog2(NFU)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            iss_valid,
  input logic            iss_ready,
  input logic [RW-1:0]   iss_dst,
  input logic [UW-1:0]   iss_unit,
  input logic [NFU-1:0]  rd_go,
  input logic [NFU-1:0]  wb_req,
  input logic [NFU-1:0]  wb_grant,
  input logic [NREG-1:0] reg_busy,
  input logic [NFU-1:0]  unit_busy
);
  AST_WAW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && reg_busy[iss_dst]) |-> !iss_ready); // R2

  AST_UNIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && unit_busy[iss_unit]) |-> !iss_ready); // R3

  AST_ISSUE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> (reg_busy[$past(iss_dst)] && unit_busy[$past(iss_unit)])); // R3

  AST_GO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go & ~unit_busy) == '0); // R6

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wb_grant)); // R8

  AST_GRANT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_grant & ~wb_req) == '0); // R8

  AST_GRANT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (|wb_grant) |=> (($past(wb_grant) & unit_busy) == '0)); // R9
endmodule

bind reg_scoreboard reg_scoreboard_chk #(.NREG(NREG), .NFU(NFU)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_valid (iss_valid),
  .iss_ready (iss_ready),
  .iss_dst   (iss_dst),
  .iss_unit  (iss_unit),
  .rd_go     (rd_go),
  .wb_req    (wb_req),
  .wb_grant  (wb_grant),
  .reg_busy  (reg_busy),
  .unit_busy (unit_busy)
);

// File: tb/reg_scoreboard_tb_top.sv
module reg_scoreboard_tb_top;
  localparam int NREG = 8;
  localparam int NFU  = 4;
  localparam int NV   = 15;

  typedef struct packed {
    logic       iv;
    logic [2:0] dst;
    logic [2:0] sa;
    logic       ua;
    logic [2:0] sb;
    logic       ub;
    logic [1:0] unit;
    logic [3:0] rdd;
    logic [3:0] wbq;
    logic       e_rdy;
    logic [3:0] e_go;
    logic [3:0] e_gnt;
    logic [7:0] e_rb;
    logic [3:0] e_ub;
  } vec_t;

  // Each row: drive fields, then the expected combinational outputs and state before the edge.
  localparam vec_t VEC [NV] = '{
    {1'b1,3'd1,3'd2,1'b1,3'd0,1'b0,2'd0,4'b0000,4'b0000,1'b1,4'b0000,4'b0000,8'b00000000,4'b0000},
    {1'b1,3'd3,3'd1,1'b1,3'd4,1'b1,2'd1,4'b0000,4'b0000,1'b1,4'b0001,4'b0000,8'b00000010,4'b0001},
    {1'b1,3'd1,3'd0,1'b0,3'd0,1'b0,2'd2,4'b0001,4'b0000,1'b0,4'b0001,4'b0000,8'b00001010,4'b0011},
    {1'b1,3'd5,3'd0,1'b0,3'd0,1'b0,2'd1,4'b0000,4'b0001,1'b0,4'b0010,4'b0001,8'b00001010,4'b0011},
    {1'b1,3'd4,3'd0,1'b0,3'd0,1'b0,2'd2,4'b0000,4'b0000,1'b1,4'b0010,4'b0000,8'b00001000,4'b0010},
    {1'b0,3'd0,3'd0,1'b0,3'd0,1'b0,2'd0,4'b0100,4'b0000,1'b1,4'b0110,4'b0000,8'b00011000,4'b0110},
    {1'b1,3'd6,3'd3,1'b1,3'd0,1'b0,2'd3,4'b0000,4'b0100,1'b1,4'b0010,4'b0000,8'b00011000,4'b0110},
    {1'b0,3'd0,3'd0,1'b0,3'd0,1'b0,2'd0,4'b0010,4'b0100,1'b1,4'b0010,4'b0000,8'b01011000,4'b1110},
    {1'b0,3'd0,3'd0,1'b0,3'd0,1'b0,2'd0,4'b0000,4'b0110,1'b1,4'b1000,4'b0010,8'b01011000,4'b1110},
    {1'b1,3'd7,3'd4,1'b1,3'd0,1'b0,2'd1,4'b0000,4'b0100,1'b1,4'b1000,4'b0100,8'b01010000,4'b1100},
    {1'b0,3'd0,3'd0,1'b0,3'd0,1'b0,2'd0,4'b1001,4'b0000,1'b1,4'b1010,4'b0000,8'b11000000,4'b1010},
    {1'b0,3'd0,3'd0,1'b0,3'd0,1'b0,2'd0,4'b0000,4'b1001,1'b1,4'b0010,4'b1000,8'b11000000,4'b1010},
    {1'b0,3'd0,3'd0,1'b0,3'd0,1'b0,2'd0,4'b0010,4'b0010,1'b1,4'b0010,4'b0000,8'b10000000,4'b0010},
    {1'b0,3'd0,3'd0,1'b0,3'd0,1'b0,2'd0,4'b0000,4'b0010,1'b1,4'b0000,4'b0010,8'b10000000,4'b0010},
    {1'b0,3'd0,3'd0,1'b0,3'd0,1'b0,2'd0,4'b0000,4'b0000,1'b1,4'b0000,4'b0000,8'b00000000,4'b0000}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           iss_valid = 1'b0;
  logic           iss_ready;
  logic [2:0]     iss_dst = '0, iss_src_a = '0, iss_src_b = '0;
  logic           iss_use_a = 1'b0, iss_use_b = 1'b0;
  logic [1:0]     iss_unit = '0;
  logic [NFU-1:0] rd_go, wb_grant, unit_busy;
  logic [NFU-1:0] rd_done = '0, wb_req = '0;
  logic [NREG-1:0] reg_busy;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  reg_scoreboard #(.NREG(NREG), .NFU(NFU)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_dst(iss_dst), .iss_src_a(iss_src_a), .iss_use_a(iss_use_a),
    .iss_src_b(iss_src_b), .iss_use_b(iss_use_b), .iss_unit(iss_unit),
    .rd_go(rd_go), .rd_done(rd_done),
    .wb_req(wb_req), .wb_grant(wb_grant),
    .reg_busy(reg_busy), .unit_busy(unit_busy)
  );

  task automatic check(input string what, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", what, got, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    iss_valid = 1'b0; iss_dst = '0; iss_src_a = '0; iss_src_b = '0;
    iss_use_a = 1'b0; iss_use_b = 1'b0; iss_unit = '0;
    rd_done = '0; wb_req = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: state during reset
    repeat (3) @(negedge clk);
    #1;
    check("R1 reg_busy in reset", 8'(reg_busy), 8'h00);
    check("R1 unit_busy in reset", 8'(unit_busy), 8'h00);
    check("R1 rd_go in reset", 8'(rd_go), 8'h00);
    rst_n = 1'b1;

    // Scenario table: R2/R3 issue holds, R4/R5 read waits and bypass,
    // R6 stray rd_done, R7 WAR hold, R8 lowest index, R9 release.
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      @(negedge clk);
      v = VEC[i];
      iss_valid = v.iv; iss_dst = v.dst; iss_src_a = v.sa; iss_use_a = v.ua;
      iss_src_b = v.sb; iss_use_b = v.ub; iss_unit = v.unit;
      rd_done = v.rdd; wb_req = v.wbq;
      #1;
      check($sformatf("R2 iss_ready step %0d", i), 8'(iss_ready), 8'(v.e_rdy));
      check($sformatf("R4 rd_go step %0d", i), 8'(rd_go), 8'(v.e_go));
      check($sformatf("R7 wb_grant step %0d", i), 8'(wb_grant), 8'(v.e_gnt));
      check($sformatf("R9 reg_busy step %0d", i), 8'(reg_busy), v.e_rb);
      check($sformatf("R3 unit_busy step %0d", i), 8'(unit_busy), 8'(v.e_ub));
    end
    @(negedge clk);
    idle_inputs();

    // R4: disabled sources naming a pending register do not hold rd_go
    @(negedge clk);
    iss_valid = 1'b1; iss_dst = 3'd2; iss_unit = 2'd0;
    @(negedge clk);
    iss_dst = 3'd5; iss_src_a = 3'd2; iss_src_b = 3'd2; iss_unit = 2'd1;
    #1;
    check("R3 iss_ready second unit", 8'(iss_ready), 8'h01);
    @(negedge clk);
    idle_inputs();
    #1;
    check("R4 rd_go with disabled sources", 8'(rd_go), 8'b0000_0011);
    check("R3 reg_busy after two issues", 8'(reg_busy), 8'b0010_0100);

    // R1: reset in the middle of activity clears everything
    rst_n = 1'b0;
    #1;
    check("R1 reg_busy after mid reset", 8'(reg_busy), 8'h00);
    check("R1 unit_busy after mid reset", 8'(unit_busy), 8'h00);
    check("R1 rd_go after mid reset", 8'(rd_go), 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 iss_ready after reset", 8'(iss_ready), 8'h01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule